// File: doc/BRIEF.md
# Per-Processor Local and Redirected Register Bank

This block keeps a small private register set for each of up to eight virtual processors sharing one memory-mapped port. Each set has two registers: a reset exception base and a pointer naming another processor. A bus request carries the index of the processor that issued it. The local window reaches the requester's own set. The redirect window reaches the set of whichever processor the requester's pointer names, so that one processor can prepare the start address of another before releasing it.

Every processor gets a 64-bit exception-base output. It is the stored base, sign-extended, and it follows each accepted base write on the next clock edge. A read-only config register reports the number of processors minus one. Reads return data one cycle later, together with a strobe. Writes give no response.

Top module: `vp_regbank`

## Requirements
- R1: After reset, every processor's stored base reads 0xBFC00000, every pointer reads 0, and every exception-base lane is 0xFFFFFFFFBFC00000.
- R2: Address bit 8 selects the window: 0 is local and 1 is redirect. Bits 7:0 are the register offset: 0x10 is config, 0x18 is the pointer and 0x20 is the base. The layout is the same in both windows.
- R3: A pointer write keeps write-data bits 2:0 only. If that value is not below NUM_VP, the write is dropped and the old pointer stays. A pointer read returns zero in bits 31:3.
- R4: A base write stores write-data bits 31:12. Bits 11:0 of the base always read back as zero.
- R5: Lane i of `exc_base_o` (bits 64*i+63 down to 64*i) is processor i's stored base sign-extended from bit 31. It changes on the clock edge that accepts the write.
- R6: A redirect-window access targets the processor named by the requester's pointer as it stands in the cycle of the access. A redirect write changes only that processor's register and lane.
- R7: Config reads NUM_VP-1 in both windows. Writes to config have no effect.
- R8: A read gives `rsp_valid_o` high for exactly the next cycle, with the data on `rsp_rdata_o` in that cycle. Writes never raise `rsp_valid_o`.
- R9: Reads of any other offset return zero. Writes to any other offset change no register and no lane.
- R10: A requester index at or above NUM_VP acts as processor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_vp_i | input | 3 | Index of the requesting processor |
| req_addr_i | input | 9 | Window bit and register offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Read data |
| exc_base_o | output | 64*NUM_VP | Exception base for each processor, one lane each |

## Verification
Redirect resolution and a pointer update can collide. This happens when a requester whose pointer names itself rewrites that pointer through the redirect window, then issues a redirect read in the very next cycle. The bench sets this up with back-to-back tasks, making processor 3 point at itself and then at processor 0. It passes only if the read returns processor 0's base, which shows that the new pointer was used with no stale cycle. A second collision occurs when a redirect write lands on a lane while the requester's own lane must stay unchanged. The bench judges this by comparing both lanes in the cycle after the write.

// File: rtl/vp_regbank_pkg.sv
package vp_regbank_pkg;
  localparam int          DATA_W     = 32;
  localparam int          PTR_W      = 3;
  localparam logic [7:0]  OFS_CONFIG = 8'h10;
  localparam logic [7:0]  OFS_PTR    = 8'h18;
  localparam logic [7:0]  OFS_BASE   = 8'h20;
  localparam logic [31:0] BASE_MASK  = 32'hFFFF_F000;
  localparam logic [31:0] BASE_RST   = 32'hBFC0_0000;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_CONFIG,
    REG_PTR,
    REG_BASE
  } reg_sel_e;
endpackage

// File: rtl/vp_regbank_decode.sv
module vp_regbank_decode
  import vp_regbank_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int ADDR_W = 9
) (
  input  logic [PTR_W-1:0]  req_vp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PTR_W-1:0]  ptr_i [NUM_VP],
  output logic [PTR_W-1:0]  tgt_vp_o,
  output reg_sel_e          reg_sel_o
);
  logic [PTR_W-1:0] self_idx;
  logic [PTR_W-1:0] self_ptr;
  logic             other_win;

  assign other_win = addr_i[ADDR_W-1];

  // R10: an out-of-range requester acts as processor 0
  assign self_idx = ({1'b0, req_vp_i} < (PTR_W+1)'(NUM_VP)) ? req_vp_i : '0;

  always_comb begin
    self_ptr = '0;
    for (int i = 0; i < NUM_VP; i++) begin
      if (self_idx == PTR_W'(i)) self_ptr = ptr_i[i];
    end
  end

  assign tgt_vp_o = other_win ? self_ptr : self_idx;

  always_comb begin
    unique case (addr_i[7:0])
      OFS_CONFIG: reg_sel_o = REG_CONFIG;
      OFS_PTR:    reg_sel_o = REG_PTR;
      OFS_BASE:   reg_sel_o = REG_BASE;
      default:    reg_sel_o = REG_NONE;
    endcase
  end
endmodule

// File: rtl/vp_regbank_slot.sv
module vp_regbank_slot
  import vp_regbank_pkg::*;
#(
  parameter int NUM_VP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  reg_sel_e          reg_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [31:0]       base_o
);
  logic ptr_we, ptr_ok, base_we;

  assign ptr_we  = sel_i && we_i && (reg_sel_i == REG_PTR);
  assign base_we = sel_i && we_i && (reg_sel_i == REG_BASE);
  assign ptr_ok  = {1'b0, wdata_i[PTR_W-1:0]} < (PTR_W+1)'(NUM_VP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      base_o <= BASE_RST & BASE_MASK;
    end else begin
      if (ptr_we && ptr_ok) ptr_o  <= wdata_i[PTR_W-1:0];
      if (base_we)          base_o <= wdata_i[31:0] & BASE_MASK;
    end
  end

  AST_PTR_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we && !ptr_ok) |=> $stable(ptr_o)); // R3
  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, ptr_o} < (PTR_W+1)'(NUM_VP))); // R3
  AST_BASE_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_o[11:0] == 12'h000)); // R4
  AST_BASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_we |=> $stable(base_o)); // R9
endmodule

// File: rtl/vp_regbank.sv
module vp_regbank
  import vp_regbank_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int ADDR_W = 9,
  parameter int EXC_W  = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic [PTR_W-1:0]        req_vp_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [DATA_W-1:0]       rsp_rdata_o,
  output logic [NUM_VP*EXC_W-1:0] exc_base_o
);
  localparam logic [DATA_W-1:0] CFG_VAL = DATA_W'(NUM_VP - 1);

  logic [PTR_W-1:0] ptr_q  [NUM_VP];
  logic [31:0]      base_q [NUM_VP];
  logic [PTR_W-1:0] tgt_vp;
  reg_sel_e         reg_sel;
  logic             rd_req;
  logic [DATA_W-1:0] rd_mux;

  vp_regbank_decode #(.NUM_VP(NUM_VP), .ADDR_W(ADDR_W)) u_decode (
    .req_vp_i (req_vp_i),
    .addr_i   (req_addr_i),
    .ptr_i    (ptr_q),
    .tgt_vp_o (tgt_vp),
    .reg_sel_o(reg_sel)
  );

  for (genvar g = 0; g < NUM_VP; g++) begin : g_slot
    vp_regbank_slot #(.NUM_VP(NUM_VP)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (req_valid_i && (tgt_vp == PTR_W'(g))),
      .we_i     (req_write_i),
      .reg_sel_i(reg_sel),
      .wdata_i  (req_wdata_i),
      .ptr_o    (ptr_q[g]),
      .base_o   (base_q[g])
    );
    assign exc_base_o[g*EXC_W +: EXC_W] = {{(EXC_W-32){base_q[g][31]}}, base_q[g]};
  end

  assign rd_req = req_valid_i && !req_write_i;

  always_comb begin
    rd_mux = '0;
    if (reg_sel == REG_CONFIG) rd_mux = CFG_VAL;
    for (int i = 0; i < NUM_VP; i++) begin
      if (tgt_vp == PTR_W'(i)) begin
        if (reg_sel == REG_PTR)  rd_mux = DATA_W'(ptr_q[i]);
        if (reg_sel == REG_BASE) rd_mux = DATA_W'(base_q[i]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_req;
      rsp_rdata_o <= rd_req ? rd_mux : '0;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o); // R8
  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rsp_valid_o); // R8
  AST_CONFIG_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && reg_sel == REG_CONFIG) |=> (rsp_rdata_o == CFG_VAL)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && reg_sel == REG_NONE) |=> (rsp_rdata_o == '0)); // R9
  AST_TGT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, tgt_vp} < (PTR_W+1)'(NUM_VP))); // R6
endmodule

// File: tb/vp_regbank_tb.sv
module vp_regbank_tb;
  localparam int NV = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic            req_write_i = 1'b0;
  logic [2:0]      req_vp_i = '0;
  logic [8:0]      req_addr_i = '0;
  logic [31:0]     req_wdata_i = '0;
  logic            rsp_valid_o;
  logic [31:0]     rsp_rdata_o;
  logic [NV*64-1:0] exc_base_o;

  int n_chk = 0;
  int n_bad = 0;

  vp_regbank #(.NUM_VP(NV)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(logic [31:0] b);
    return {{32{b[31]}}, b};
  endfunction

  function automatic logic [63:0] lane(int i);
    return exc_base_o[i*64 +: 64];
  endfunction

  // called at a negedge, returns at the next negedge
  task automatic wr(logic [2:0] vp, logic [8:0] a, logic [31:0] d);
    req_valid_i = 1'b1; req_write_i = 1'b1;
    req_vp_i = vp; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
    chk("R8 no rsp on write", {63'd0, rsp_valid_o}, 64'd0);
  endtask

  task automatic rd(logic [2:0] vp, logic [8:0] a, output logic [31:0] d);
    req_valid_i = 1'b1; req_write_i = 1'b0;
    req_vp_i = vp; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!rsp_valid_o) begin
      n_chk++; n_bad++;
      $display("FAIL R8 rsp_valid actual=0 expected=1");
    end
    d = rsp_rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < NV; i++) begin
      rd(3'(i), 9'h020, d); chk("R1 base", 64'(d), 64'hBFC0_0000);
      rd(3'(i), 9'h018, d); chk("R1 ptr", 64'(d), 64'd0);
      chk("R1 lane", lane(i), 64'hFFFF_FFFF_BFC0_0000);
    end
  endtask

  task automatic t_local_base();
    logic [31:0] d;
    wr(3'd1, 9'h020, 32'h1234_5678);
    chk("R5 lane1", lane(1), 64'h0000_0000_1234_5000);
    chk("R5 lane0 held", lane(0), 64'hFFFF_FFFF_BFC0_0000);
    rd(3'd1, 9'h020, d); chk("R4 low bits", 64'(d), 64'h1234_5000);
    @(negedge clk_i);
    chk("R8 single pulse", {63'd0, rsp_valid_o}, 64'd0);
  endtask

  task automatic t_ptr();
    logic [31:0] d;
    wr(3'd0, 9'h018, 32'hFFFF_FFFA);
    rd(3'd0, 9'h018, d); chk("R3 masked ptr", 64'(d), 64'd2);
    wr(3'd0, 9'h018, 32'd5);
    rd(3'd0, 9'h018, d); chk("R3 ptr 5 dropped", 64'(d), 64'd2);
    wr(3'd0, 9'h018, 32'd4);
    rd(3'd0, 9'h018, d); chk("R3 ptr NUM_VP dropped", 64'(d), 64'd2);
    wr(3'd1, 9'h018, 32'd3);
    rd(3'd1, 9'h018, d); chk("R3 ptr max accepted", 64'(d), 64'd3);
  endtask

  task automatic t_other();
    logic [31:0] d;
    wr(3'd0, 9'h120, 32'h8000_1FFF);
    chk("R6 lane2 via redirect", lane(2), sx(32'h8000_1000));
    chk("R6 requester lane held", lane(0), 64'hFFFF_FFFF_BFC0_0000);
    rd(3'd2, 9'h020, d); chk("R6 target local view", 64'(d), 64'h8000_1000);
    wr(3'd0, 9'h118, 32'd1);
    rd(3'd2, 9'h018, d); chk("R6 target ptr", 64'(d), 64'd1);
    rd(3'd0, 9'h018, d); chk("R6 requester ptr held", 64'(d), 64'd2);
    rd(3'd1, 9'h120, d); chk("R2 redirect read vp1->vp3", 64'(d), 64'hBFC0_0000);
  endtask

  task automatic t_config();
    logic [31:0] d;
    rd(3'd2, 9'h010, d); chk("R7 local config", 64'(d), 64'd3);
    wr(3'd0, 9'h110, 32'hFFFF_FFFF);
    rd(3'd0, 9'h110, d); chk("R7 redirect config", 64'(d), 64'd3);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(3'd3, 9'h024, 32'hDEAD_B000);
    wr(3'd3, 9'h030, 32'h0000_0002);
    chk("R9 lane3 held", lane(3), 64'hFFFF_FFFF_BFC0_0000);
    rd(3'd3, 9'h020, d); chk("R9 base held", 64'(d), 64'hBFC0_0000);
    rd(3'd3, 9'h018, d); chk("R9 ptr held", 64'(d), 64'd0);
    rd(3'd3, 9'h030, d); chk("R9 read zero", 64'(d), 64'd0);
    rd(3'd0, 9'h1FC, d); chk("R9 redirect read zero", 64'(d), 64'd0);
  endtask

  task automatic t_req_oob();
    logic [31:0] d;
    wr(3'd6, 9'h020, 32'h1111_1ABC);
    chk("R10 lane0", lane(0), 64'h0000_0000_1111_1000);
    rd(3'd7, 9'h020, d); chk("R10 read as vp0", 64'(d), 64'h1111_1000);
    rd(3'd5, 9'h018, d); chk("R10 ptr as vp0", 64'(d), 64'd2);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(3'd3, 9'h018, 32'd3);
    wr(3'd3, 9'h118, 32'd0);
    rd(3'd3, 9'h120, d); chk("R6 back-to-back new ptr", 64'(d), 64'h1111_1000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle after reset", {63'd0, rsp_valid_o}, 64'd0);
    t_reset();
    t_local_base();
    t_ptr();
    t_other();
    t_config();
    t_unmapped();
    t_req_oob();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule